// File: doc/BRIEF.md
# Matrix Key Event Differ

This block turns successive polls of a scanned key matrix into a stream of key events. Each poll delivers a snapshot of up to eight entry slots, each naming one pressed matrix position. The block compares the snapshot with the key set it last reported. It then emits release events for keys that went away, press events for every key now down, and a sync marker. Events leave one at a time on a valid/ready stream.

Two filters act on a snapshot before it is compared. When ghost rejection is enabled, a snapshot that could contain phantom keys is discarded whole. In that case the reported set is left as it was. When the function layer is enabled, a key whose keycode equals the function code is swallowed. Every other key in that snapshot is then moved into the upper half of the scancode space before its keycode is looked up. Keycodes come from an internal table that is loaded through a simple write port.

Top module: `kd_key_differ`

## Requirements
- R1: A snapshot slot is 8 bits: bit 7 valid, bits 6:3 row, bits 2:0 column; slot k sits at bits 8k+7:8k. A valid slot has scancode row*8+column. The keycode reported is the table entry at the scancode. A table write takes effect for every snapshot accepted after it. Slots with bit 7 clear are ignored whatever their other bits hold.
- R2: After reset, snap_ready_o is 1 and ev_valid_o is 0. snap_ready_o is 1 only while no snapshot is being processed, and it is 0 whenever ev_valid_o is 1.
- R3: Release events (kind 0, scancode field 0) come first. There is one for each held keycode that is absent from the new set, in the slot order of the snapshot that set it.
- R4: After the releases comes one press event (kind 1) for each reported key of the new set, in slot order. It carries the scancode and the keycode.
- R5: Every snapshot that is not dropped ends with a sync event (kind 2, fields 0). The held set becomes the new set when the sync is accepted, and snap_ready_o is 1 on the next cycle.
- R6: A snapshot with no valid slot releases every held key, then syncs, and leaves the held set empty.
- R7: With ghost rejection on and at least three reported keys, a snapshot is dropped when one pair of its keys shares a row and one pair shares a column. A dropped snapshot produces no event and leaves the held set unchanged.
- R8: With ghost rejection off, with fewer than three keys, or with only a row pair or only a column pair, the snapshot is processed normally.
- R9: With the function layer on, a valid slot whose table entry equals FN_CODE (default 0xF0) is not reported. If such a slot is present, every other key reports scancode row*8+column+128 and the keycode held at that scancode.
- R10: With the function layer off, a key mapping to FN_CODE is reported like any other key.
- R11: While ev_valid_o is 1 and ev_ready_i is 0, the event kind, scancode and keycode are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ghost_en_i | input | 1 | Enable ghost rejection |
| fn_mode_i | input | 1 | Enable the function layer |
| map_we_i | input | 1 | Keycode table write strobe |
| map_addr_i | input | 8 | Keycode table write address (scancode) |
| map_data_i | input | 8 | Keycode table write data |
| snap_valid_i | input | 1 | Snapshot offered |
| snap_ready_o | output | 1 | Snapshot accepted when high with snap_valid_i |
| snap_i | input | 64 | Eight entry slots |
| ev_valid_o | output | 1 | Event available |
| ev_ready_i | input | 1 | Event consumed |
| ev_kind_o | output | 2 | 0 release, 1 press, 2 sync |
| ev_scan_o | output | 8 | Scancode of a press event |
| ev_code_o | output | 8 | Keycode of a release or press event |

## Verification
A corrupted held set shows up at the first snapshot after it. A spurious release or a missing release appears among the first eight event slots, before any press. A wrong ghost or function decision shows on the very snapshot that triggers it: either the whole event burst is missing, or the press scancodes are off by 128. Stalls on the event stream are driven on purpose, so a payload that moves under backpressure is seen on the cycle it changes.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef enum logic [1:0] {
    EV_RELEASE = 2'd0,
    EV_PRESS   = 2'd1,
    EV_SYNC    = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/kd_keymap.sv
module kd_keymap #(
  parameter int SCAN_W = 8,
  parameter int CODE_W = 8,
  parameter int NRD    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SCAN_W-1:0]      waddr_i,
  input  logic [CODE_W-1:0]      wdata_i,
  input  logic [NRD*SCAN_W-1:0]  raddr_a_i,
  output logic [NRD*CODE_W-1:0]  rdata_a_o,
  input  logic [NRD*SCAN_W-1:0]  raddr_b_i,
  output logic [NRD*CODE_W-1:0]  rdata_b_o
);
  localparam int DEPTH = 1 << SCAN_W;

  logic [CODE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_a_o[g*CODE_W +: CODE_W] = mem_q[raddr_a_i[g*SCAN_W +: SCAN_W]];
    assign rdata_b_o[g*CODE_W +: CODE_W] = mem_q[raddr_b_i[g*SCAN_W +: SCAN_W]];
  end

  // R1
  map_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/kd_snap_eval.sv
module kd_snap_eval #(
  parameter int              N_ENT   = 8,
  parameter int              ROW_W   = 4,
  parameter int              COL_W   = 3,
  parameter int              CODE_W  = 8,
  parameter logic [CODE_W-1:0] FN_CODE = 8'hF0,
  parameter int              ENT_W   = 1 + ROW_W + COL_W,
  parameter int              SCAN_W  = 1 + ROW_W + COL_W
) (
  input  logic [N_ENT*ENT_W-1:0]  ent_i,
  input  logic                    ghost_en_i,
  input  logic                    fn_mode_i,
  output logic [N_ENT*SCAN_W-1:0] raw_addr_o,
  input  logic [N_ENT*CODE_W-1:0] raw_code_i,
  output logic [N_ENT*SCAN_W-1:0] fin_addr_o,
  input  logic [N_ENT*CODE_W-1:0] fin_code_i,
  output logic [N_ENT-1:0]        keep_o,
  output logic [N_ENT*SCAN_W-1:0] scan_o,
  output logic [N_ENT*CODE_W-1:0] code_o,
  output logic                    ghost_o
);
  logic [N_ENT-1:0] vld, is_fn;
  logic [ROW_W-1:0] row_a [N_ENT];
  logic [COL_W-1:0] col_a [N_ENT];
  logic             fn_any;
  logic             same_row, same_col;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign vld[i]   = ent_i[i*ENT_W + ENT_W - 1];
    assign row_a[i] = ent_i[i*ENT_W + COL_W +: ROW_W];
    assign col_a[i] = ent_i[i*ENT_W +: COL_W];
    assign raw_addr_o[i*SCAN_W +: SCAN_W] = {1'b0, row_a[i], col_a[i]};
    assign is_fn[i] = fn_mode_i && vld[i] && (raw_code_i[i*CODE_W +: CODE_W] == FN_CODE);
    assign keep_o[i] = vld[i] && !is_fn[i];
    // function layer lives in the upper half of the scancode space
    assign fin_addr_o[i*SCAN_W +: SCAN_W] = {fn_any, row_a[i], col_a[i]};
    assign scan_o[i*SCAN_W +: SCAN_W]     = {fn_any, row_a[i], col_a[i]};
    assign code_o[i*CODE_W +: CODE_W]     = fin_code_i[i*CODE_W +: CODE_W];
  end

  assign fn_any = |is_fn;

  always_comb begin
    same_row = 1'b0;
    same_col = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      for (int j = i + 1; j < N_ENT; j++) begin
        if (keep_o[i] && keep_o[j]) begin
          if (row_a[i] == row_a[j]) same_row = 1'b1;
          if (col_a[i] == col_a[j]) same_col = 1'b1;
        end
      end
    end
  end

  assign ghost_o = ghost_en_i && ($countones(keep_o) >= 3) && same_row && same_col;
endmodule

// File: rtl/kd_event_seq.sv
module kd_event_seq
  import kd_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int SCAN_W = 8,
  parameter int CODE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_ENT-1:0]        keep_i,
  input  logic [N_ENT*SCAN_W-1:0] scan_i,
  input  logic [N_ENT*CODE_W-1:0] code_i,
  output logic                    busy_o,
  output logic                    ev_valid_o,
  input  logic                    ev_ready_i,
  output ev_kind_e                ev_kind_o,
  output logic [SCAN_W-1:0]       ev_scan_o,
  output logic [CODE_W-1:0]       ev_code_o
);
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REL, S_PRS, S_SYN} state_e;

  state_e            state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [N_ENT-1:0]  nmask_q, hmask_q;
  logic [SCAN_W-1:0] nscan_q [N_ENT];
  logic [CODE_W-1:0] ncode_q [N_ENT];
  logic [CODE_W-1:0] hcode_q [N_ENT];
  logic              rel_need, step, last;

  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < N_ENT; j++)
      if (nmask_q[j] && ncode_q[j] == hcode_q[idx_q]) hit = 1'b1;
    rel_need = hmask_q[idx_q] && !hit;
  end

  always_comb begin
    ev_valid_o = 1'b0;
    ev_kind_o  = EV_SYNC;
    ev_scan_o  = '0;
    ev_code_o  = '0;
    unique case (state_q)
      S_REL: begin
        ev_valid_o = rel_need;
        ev_kind_o  = EV_RELEASE;
        ev_code_o  = hcode_q[idx_q];
      end
      S_PRS: begin
        ev_valid_o = nmask_q[idx_q];
        ev_kind_o  = EV_PRESS;
        ev_scan_o  = nscan_q[idx_q];
        ev_code_o  = ncode_q[idx_q];
      end
      S_SYN:   ev_valid_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
  assign step   = !ev_valid_o || ev_ready_i;
  assign last   = (idx_q == IDX_W'(N_ENT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      nmask_q <= '0;
      hmask_q <= '0;
      for (int k = 0; k < N_ENT; k++) begin
        nscan_q[k] <= '0;
        ncode_q[k] <= '0;
        hcode_q[k] <= '0;
      end
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          nmask_q <= keep_i;
          for (int k = 0; k < N_ENT; k++) begin
            nscan_q[k] <= scan_i[k*SCAN_W +: SCAN_W];
            ncode_q[k] <= code_i[k*CODE_W +: CODE_W];
          end
          idx_q   <= '0;
          state_q <= S_REL;
        end
        S_REL, S_PRS: if (step) begin
          idx_q <= last ? '0 : idx_q + 1'b1;
          if (last) state_q <= (state_q == S_REL) ? S_PRS : S_SYN;
        end
        S_SYN: if (ev_ready_i) begin
          hmask_q <= nmask_q;
          for (int k = 0; k < N_ENT; k++) hcode_q[k] <= ncode_q[k];
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11
  ev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && !ev_ready_i |=> ev_valid_o && $stable(ev_kind_o)
      && $stable(ev_scan_o) && $stable(ev_code_o));

  // R3
  rel_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_kind_o == EV_PRESS |=> !(ev_valid_o && ev_kind_o == EV_RELEASE));

  // R5
  sync_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o && ev_ready_i && ev_kind_o == EV_SYNC |=> !busy_o);
endmodule

// File: rtl/kd_key_differ.sv
module kd_key_differ
  import kd_pkg::*;
#(
  parameter int                N_ENT   = 8,
  parameter int                ROW_W   = 4,
  parameter int                COL_W   = 3,
  parameter int                CODE_W  = 8,
  parameter logic [CODE_W-1:0] FN_CODE = 8'hF0,
  parameter int                ENT_W   = 1 + ROW_W + COL_W,
  parameter int                SCAN_W  = 1 + ROW_W + COL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ghost_en_i,
  input  logic                   fn_mode_i,
  input  logic                   map_we_i,
  input  logic [SCAN_W-1:0]      map_addr_i,
  input  logic [CODE_W-1:0]      map_data_i,
  input  logic                   snap_valid_i,
  output logic                   snap_ready_o,
  input  logic [N_ENT*ENT_W-1:0] snap_i,
  output logic                   ev_valid_o,
  input  logic                   ev_ready_i,
  output logic [1:0]             ev_kind_o,
  output logic [SCAN_W-1:0]      ev_scan_o,
  output logic [CODE_W-1:0]      ev_code_o
);
  logic [N_ENT*SCAN_W-1:0] raw_addr, fin_addr, scan;
  logic [N_ENT*CODE_W-1:0] raw_code, fin_code, code;
  logic [N_ENT-1:0]        keep;
  logic                    ghost, busy, accept;
  ev_kind_e                kind;

  kd_keymap #(.SCAN_W(SCAN_W), .CODE_W(CODE_W), .NRD(N_ENT)) u_map (
    .clk_i, .rst_ni,
    .we_i      (map_we_i),
    .waddr_i   (map_addr_i),
    .wdata_i   (map_data_i),
    .raddr_a_i (raw_addr),
    .rdata_a_o (raw_code),
    .raddr_b_i (fin_addr),
    .rdata_b_o (fin_code)
  );

  kd_snap_eval #(
    .N_ENT(N_ENT), .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W),
    .FN_CODE(FN_CODE), .ENT_W(ENT_W), .SCAN_W(SCAN_W)
  ) u_eval (
    .ent_i      (snap_i),
    .ghost_en_i (ghost_en_i),
    .fn_mode_i  (fn_mode_i),
    .raw_addr_o (raw_addr),
    .raw_code_i (raw_code),
    .fin_addr_o (fin_addr),
    .fin_code_i (fin_code),
    .keep_o     (keep),
    .scan_o     (scan),
    .code_o     (code),
    .ghost_o    (ghost)
  );

  assign snap_ready_o = !busy;
  assign accept       = snap_valid_i && snap_ready_o;

  kd_event_seq #(.N_ENT(N_ENT), .SCAN_W(SCAN_W), .CODE_W(CODE_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (accept && !ghost),
    .keep_i     (keep),
    .scan_i     (scan),
    .code_i     (code),
    .busy_o     (busy),
    .ev_valid_o (ev_valid_o),
    .ev_ready_i (ev_ready_i),
    .ev_kind_o  (kind),
    .ev_scan_o  (ev_scan_o),
    .ev_code_o  (ev_code_o)
  );

  assign ev_kind_o = kind;

  // R7
  ghost_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && ghost |=> snap_ready_o && !ev_valid_o);

  // R2
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> !snap_ready_o);
endmodule

// File: tb/kd_key_differ_bench.sv
module kd_key_differ_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ghost_en = 1'b0, fn_mode = 1'b0;
  logic        map_we = 1'b0;
  logic [7:0]  map_addr = '0, map_data = '0;
  logic        snap_valid = 1'b0;
  logic        snap_ready;
  logic [63:0] snap = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic [1:0]  ev_kind;
  logic [7:0]  ev_scan, ev_code;

  int n_chk = 0, n_fail = 0;

  logic [7:0]  bt [256];
  logic        hv [8];
  logic [7:0]  hc [8];
  int          exp_n, got_n;
  logic [17:0] exp_e [32];
  logic [17:0] got_e [32];

  always #2.5 clk = ~clk;

  kd_key_differ u_kd_key_differ (
    .clk_i(clk), .rst_ni(rst_n), .ghost_en_i(ghost_en), .fn_mode_i(fn_mode),
    .map_we_i(map_we), .map_addr_i(map_addr), .map_data_i(map_data),
    .snap_valid_i(snap_valid), .snap_ready_o(snap_ready), .snap_i(snap),
    .ev_valid_o(ev_valid), .ev_ready_i(ev_ready), .ev_kind_o(ev_kind),
    .ev_scan_o(ev_scan), .ev_code_o(ev_code)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ent(input int row, input int col);
    return {1'b1, 4'(row), 3'(col)};
  endfunction

  task automatic map_write(input int a, input logic [7:0] d);
    @(negedge clk);
    map_we = 1'b1; map_addr = 8'(a); map_data = d; bt[a] = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  // Reference model built from the requirements; returns 1 when the snapshot is dropped.
  function automatic bit model(input logic [63:0] s);
    bit v [8], kp [8];
    int row [8], col [8];
    bit fn_any = 0, srow = 0, scol = 0;
    int cnt = 0;
    logic [7:0] sc [8], kc [8];
    exp_n = 0;
    for (int i = 0; i < 8; i++) begin
      v[i] = s[8*i+7]; row[i] = int'(s[8*i+3 +: 4]); col[i] = int'(s[8*i +: 3]);
      kp[i] = v[i] && !(fn_mode && bt[row[i]*8+col[i]] == 8'hF0);
      if (v[i] && !kp[i]) fn_any = 1;
      if (kp[i]) cnt++;
    end
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++)
        if (kp[i] && kp[j]) begin
          if (row[i] == row[j]) srow = 1;
          if (col[i] == col[j]) scol = 1;
        end
    if (ghost_en && cnt >= 3 && srow && scol) return 1;
    for (int i = 0; i < 8; i++) begin
      sc[i] = 8'(row[i]*8 + col[i] + (fn_any ? 128 : 0));
      kc[i] = bt[sc[i]];
    end
    for (int i = 0; i < 8; i++)
      if (hv[i]) begin
        bit found = 0;
        for (int j = 0; j < 8; j++) if (kp[j] && kc[j] == hc[i]) found = 1;
        if (!found) begin exp_e[exp_n] = {2'd0, 8'd0, hc[i]}; exp_n++; end
      end
    for (int i = 0; i < 8; i++)
      if (kp[i]) begin exp_e[exp_n] = {2'd1, sc[i], kc[i]}; exp_n++; end
    exp_e[exp_n] = {2'd2, 16'd0}; exp_n++;
    for (int i = 0; i < 8; i++) begin hv[i] = kp[i]; hc[i] = kc[i]; end
    return 0;
  endfunction

  task automatic run_snap(input logic [63:0] s, input bit bp, input string tag);
    bit drop, done, prev_stall, r2_done;
    logic [17:0] prev_p, pay;
    drop = model(s);
    @(negedge clk);
    snap_valid = 1'b1; snap = s;
    chk(snap_ready == 1'b1, "R2", "ready before accept", snap_ready, 1);
    @(negedge clk);
    snap_valid = 1'b0; snap = 64'hA5A5_5A5A_0F0F_7070;
    if (drop) begin
      for (int c = 0; c < 4; c++) begin
        chk(!ev_valid && snap_ready, tag, "dropped snapshot idle", {ev_valid, snap_ready}, 2'b01);
        @(negedge clk);
      end
      return;
    end
    got_n = 0; done = 0; prev_stall = 0; r2_done = 0; prev_p = '0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      ev_ready = bp ? (cyc % 3 != 0) : 1'b1;
      pay = {ev_kind, ev_scan, ev_code};
      if (prev_stall) chk(ev_valid && pay == prev_p, "R11", "payload under stall", pay, prev_p);
      if (ev_valid && !r2_done) begin
        chk(!snap_ready, "R2", "ready during events", snap_ready, 0);
        r2_done = 1;
      end
      prev_stall = ev_valid && !ev_ready;
      prev_p = pay;
      if (ev_valid && ev_ready) begin
        if (got_n < 32) got_e[got_n] = pay;
        got_n++;
        if (ev_kind == 2'd2) done = 1;
      end
      @(negedge clk);
    end
    ev_ready = 1'b0;
    chk(got_n == exp_n, tag, "event count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n && i < 32; i++)
      chk(got_e[i] == exp_e[i], tag, $sformatf("event %0d {kind,scan,code}", i), got_e[i], exp_e[i]);
    chk(snap_ready == 1'b1, "R5", "ready after sync", snap_ready, 1);
  endtask

  task automatic t_reset();
    chk(snap_ready == 1'b1, "R2", "reset ready", snap_ready, 1);
    chk(ev_valid == 1'b0, "R2", "reset valid", ev_valid, 0);
  endtask

  task automatic t_load();
    for (int s = 0; s < 256; s++) map_write(s, (s == 7) ? 8'hF0 : 8'(s*3 + 1));
    for (int i = 0; i < 8; i++) begin hv[i] = 0; hc[i] = '0; end
  endtask

  task automatic t_basic();
    run_snap({56'd0, ent(2,3)}, 0, "R4");                // R1 R4 R5
    run_snap({48'd0, ent(5,1), ent(2,3)}, 1, "R11");     // presses under stall
    run_snap({56'd0, ent(5,1)}, 0, "R3");                // release of 2,3
    run_snap({8'h7F, 40'd0, ent(5,1), 8'h5A}, 0, "R1");  // invalid slots ignored
  endtask

  task automatic t_ghost();
    ghost_en = 1'b1;
    run_snap({40'd0, ent(3,1), ent(1,2), ent(1,1)}, 0, "R7");
    run_snap({56'd0, ent(5,1)}, 0, "R7");                // held set kept
    run_snap({40'd0, ent(1,4), ent(1,2), ent(1,1)}, 0, "R8");
    run_snap({48'd0, ent(3,1), ent(1,1)}, 0, "R8");
    ghost_en = 1'b0;
    run_snap({40'd0, ent(3,1), ent(1,2), ent(1,1)}, 1, "R8");
  endtask

  task automatic t_fn();
    fn_mode = 1'b1;
    run_snap({48'd0, ent(2,3), ent(0,7)}, 0, "R9");
    run_snap({56'd0, ent(2,3)}, 0, "R9");
    fn_mode = 1'b0;
    run_snap({48'd0, ent(2,3), ent(0,7)}, 0, "R10");
  endtask

  task automatic t_empty();
    run_snap(64'd0, 1, "R6");
    run_snap(64'd0, 0, "R6");
  endtask

  task automatic t_remap();
    map_write(19, 8'h33);
    run_snap({56'd0, ent(2,3)}, 0, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_basic();
    t_ghost();
    t_fn();
    t_empty();
    t_remap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule